// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is a byte-wide general-purpose I/O port attached to a simple register bus. Each pin is set up on its own. It can be an input, or an output driven from a port data register, or it can be handed over to a peripheral. The peripheral then supplies that pin's output value and its output enable.

Pin levels pass through a synchronizer before anything uses them. Software reads them back from the input register. A selected signal change on any pin sets that pin's interrupt flag. The flags that are both pending and enabled are combined into one interrupt request line. A build parameter marks which pins are bonded out. An unbonded pin never raises its flag, but its flag bit can still be read and written.

Top module: `pio_edge_port`

## Requirements
- R1: After reset every register holds 0. `pin_oe` is 0 and `irq` is low.
- R2: Register offsets are fixed: 0 pin input (read-only, writes ignored), 1 output data, 2 direction, 3 edge select, 4 interrupt flags, 5 interrupt enable, 6 function select. Offset 7 reads 0. A read with `bus_rd` high is returned on `bus_rdata` one clock later. A write with `bus_wr` high takes effect at that clock edge.
- R3: The input register shows a pin level two clocks after the level is presented, because of the two synchronizer stages.
- R4: When a pin's function select bit is 0, `pin_out` follows the output data bit and `pin_oe` follows the direction bit (1 = output).
- R5: When a pin's function select bit is 1, `pin_out` and `pin_oe` for that pin come from `periph_out` and `periph_oe`.
- R6: An edge select bit of 0 makes a rising synchronized edge set the flag. A bit of 1 makes a falling edge set it. The opposite edge leaves the flag unchanged. The flag becomes visible three clocks after the pin change.
- R7: A flag is set by its selected edge whatever the value of its enable bit.
- R8: Writing the flag register loads the written value, so writing 0 clears a flag. An edge in the same cycle as that write wins, and the flag ends up set.
- R9: `irq` is high exactly when the bitwise AND of the flags and the enables is nonzero.
- R10: A pin whose `BOND_MASK` bit is 0 never sets its flag through an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Raw pin levels |
| pin_out | output | WIDTH | Value to drive on each pin |
| pin_oe | output | WIDTH | Output enable per pin |
| periph_out | input | WIDTH | Peripheral output values |
| periph_oe | input | WIDTH | Peripheral output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge event that lands in the very clock cycle in which software writes a 0 to the same flag. The bench changes the pin level just after a falling clock edge. It then counts two rising edges to cover the synchronizer stages, and then launches the flag write so that it is captured on the same edge as the detected transition. A read-back of the flag register then has to show the contended bit set and every other bit cleared. Unbonded pins are toggled with both edge polarities while the flag register is watched, so a mask leak would show up at once.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_IN   = 3'd0,
      REG_OUT  = 3'd1,
      REG_DIR  = 3'd2,
      REG_EDGE = 3'd3,
      REG_FLAG = 3'd4,
      REG_IEN  = 3'd5,
      REG_FSEL = 3'd6
   } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic [WIDTH-1:0]  in_val,
   input  logic [WIDTH-1:0]  flag_val,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [WIDTH-1:0]  out_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  edge_q,
   output logic [WIDTH-1:0]  ien_q,
   output logic [WIDTH-1:0]  fsel_q,
   output logic              flag_wr
);
   logic [WIDTH-1:0] rd_mux;

   assign flag_wr = bus_wr && (bus_addr == REG_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         edge_q <= '0;
         ien_q  <= '0;
         fsel_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            REG_OUT:  out_q  <= bus_wdata;
            REG_DIR:  dir_q  <= bus_wdata;
            REG_EDGE: edge_q <= bus_wdata;
            REG_IEN:  ien_q  <= bus_wdata;
            REG_FSEL: fsel_q <= bus_wdata;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         REG_IN:   rd_mux = in_val;
         REG_OUT:  rd_mux = out_q;
         REG_DIR:  rd_mux = dir_q;
         REG_EDGE: rd_mux = edge_q;
         REG_FLAG: rd_mux = flag_val;
         REG_IEN:  rd_mux = ien_q;
         REG_FSEL: rd_mux = fsel_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/pio_flags.sv
module pio_flags #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] BOND_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_in,
   input  logic [WIDTH-1:0] edge_sel,
   input  logic [WIDTH-1:0] ien,
   input  logic             flag_wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] flag_q,
   output logic             irq
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] raw_hit;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] flag_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         raw_hit[i] = edge_sel[i] ? (prev_q[i] & ~sync_in[i])
                                  : (~prev_q[i] & sync_in[i]);
      end
   end

   assign hit    = raw_hit & BOND_MASK;
   assign flag_d = (flag_wr ? wdata : flag_q) | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign irq = |(flag_q & ien);

   for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      p_edge_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && !wdata[i] && hit[i]) |=> flag_q[i]);
      p_flag_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_wr && !hit[i]) |=> $stable(flag_q[i]));
      if (!BOND_MASK[i]) begin : g_unbonded
         p_unbonded_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !flag_wr |=> $stable(flag_q[i]));
      end
   end
endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port
   import pio_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] BOND_MASK   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   input  logic [WIDTH-1:0]  periph_out,
   input  logic [WIDTH-1:0]  periph_oe,
   output logic              irq
);
   if (WIDTH < 1) begin : g_bad_width
      $error("pio_edge_port: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_edge_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] in_sync;
   logic [WIDTH-1:0] out_q, dir_q, edge_q, ien_q, fsel_q, flag_q;
   logic             flag_wr;

   pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
   );

   pio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .in_val(in_sync), .flag_val(flag_q),
      .bus_rdata(bus_rdata), .out_q(out_q), .dir_q(dir_q),
      .edge_q(edge_q), .ien_q(ien_q), .fsel_q(fsel_q), .flag_wr(flag_wr)
   );

   pio_flags #(.WIDTH(WIDTH), .BOND_MASK(BOND_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .sync_in(in_sync), .edge_sel(edge_q),
      .ien(ien_q), .flag_wr(flag_wr), .wdata(bus_wdata),
      .flag_q(flag_q), .irq(irq)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pin_out[i] = fsel_q[i] ? periph_out[i] : out_q[i];
      assign pin_oe[i]  = fsel_q[i] ? periph_oe[i]  : dir_q[i];
   end

   p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien_q != '0));
endmodule

// File: tb/pio_edge_port_tb.sv
module pio_edge_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 0;
   logic         rst_n = 0;
   logic         bus_wr = 0, bus_rd = 0;
   logic [2:0]   bus_addr = 0;
   logic [W-1:0] bus_wdata = 0, bus_rdata;
   logic [W-1:0] pin_in = 0, pin_out, pin_oe;
   logic [W-1:0] periph_out = 0, periph_oe = 0;
   logic         irq;

   int checks = 0;
   int errors = 0;
   logic rd_seen = 0;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_edge_port #(.WIDTH(W), .SYNC_STAGES(2), .BOND_MASK(8'h3F)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .periph_out(periph_out), .periph_oe(periph_oe), .irq(irq)
   );

   always @(posedge clk) rd_seen <= bus_rd;

   // monitor: compare returned read data against scoreboard
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard underflow got %02h", bus_rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (bus_rdata !== e.exp) begin
               errors++;
               $display("FAIL %s read got %02h exp %02h", e.tag, bus_rdata, e.exp);
            end
         end
      end
   end

   task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h exp %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      sb_q.push_back(e);
      bus_rd = 1; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pin_oe, 8'h00, "R1 pin_oe");
      chk({7'b0, irq}, 8'h00, "R1 irq");
      rst_n = 1;
      for (int a = 0; a < 7; a++) rd(a[2:0], 8'h00, "R1 reset value");

      // R2 / R4: register write and readback, port-driven pins
      wr(3'd1, 8'hA5);
      wr(3'd2, 8'h0F);
      rd(3'd1, 8'hA5, "R2 out reg");
      rd(3'd2, 8'h0F, "R2 dir reg");
      chk(pin_out, 8'hA5, "R4 pin_out");
      chk(pin_oe,  8'h0F, "R4 pin_oe");
      wr(3'd0, 8'hFF);
      rd(3'd0, 8'h00, "R2 input read-only");
      rd(3'd7, 8'h00, "R2 unused offset");

      // R3: synchronizer latency; R6/R7 rising edges with enables clear
      @(negedge clk);
      pin_in = 8'h3C;
      rd(3'd0, 8'h00, "R3 one clock");
      rd(3'd0, 8'h3C, "R3 two clocks");
      idle(2);
      rd(3'd4, 8'h3C, "R6 R7 rising flags");
      chk({7'b0, irq}, 8'h00, "R7 irq masked");

      // R9: irq from enabled flag
      wr(3'd5, 8'h04);
      chk({7'b0, irq}, 8'h01, "R9 irq enabled");
      wr(3'd4, 8'h00);
      chk({7'b0, irq}, 8'h00, "R9 irq after clear");

      // R6: falling edge ignored when rising selected
      @(negedge clk);
      pin_in = 8'h00;
      idle(5);
      rd(3'd4, 8'h00, "R6 opposite edge ignored");

      // R6 falling select, R10 unbonded pins 6,7
      wr(3'd3, 8'hFF);
      @(negedge clk);
      pin_in = 8'hC1;
      idle(5);
      rd(3'd4, 8'h00, "R6 rising ignored in falling mode");
      @(negedge clk);
      pin_in = 8'h00;
      idle(5);
      rd(3'd4, 8'h01, "R10 R6 falling, unbonded quiet");

      // R10: unbonded rising edges with rising select
      wr(3'd3, 8'h00);
      @(negedge clk);
      pin_in = 8'hC0;
      idle(5);
      rd(3'd4, 8'h01, "R10 unbonded rising quiet");

      // R8: edge coincides with a clearing write
      @(negedge clk);
      pin_in = 8'hC2;
      @(posedge clk);
      @(posedge clk);
      wr(3'd4, 8'h00);
      rd(3'd4, 8'h02, "R8 edge wins over clear");

      // R9: enable selects which flag matters
      wr(3'd5, 8'h01);
      chk({7'b0, irq}, 8'h00, "R9 mismatched enable");
      wr(3'd5, 8'h02);
      chk({7'b0, irq}, 8'h01, "R9 matched enable");

      // R5: peripheral routing
      periph_out = 8'h5A;
      periph_oe  = 8'hC3;
      wr(3'd6, 8'hF0);
      chk(pin_out, 8'h55, "R5 pin_out mixed");
      chk(pin_oe,  8'hCF, "R5 pin_oe mixed");
      rd(3'd6, 8'hF0, "R2 fsel reg");

      idle(3);
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard left %0d items", sb_q.size());
      end
      finish_run();
   end
endmodule